// File: doc/BRIEF.md
# Packet Timestamp Capture Register

This block records the exact 64-bit time at which a qualified timestamped packet passes and keeps that time for software to read. Each direction has one capture slot. When the slot is armed and enabled, a capture strobe stores the live time and the packet's sequence identifier in the slot. The slot is then full, and it keeps that value until software releases it.

Software reads a status word with a valid flag at bit 16 and the captured sequence identifier in bits [15:0]. It also reads two 32-bit words that hold the low and high halves of the time. Writing a 1 to bit 16 of the status word empties the slot and re-arms it. A rising edge on the enable input, which marks timestamping being switched on or reconfigured, also empties the slot so that no stale value survives. The receive slot and the transmit slot are two identical, independent instances that share the live time input.

Top module: `ts_capture_pair`

## Requirements
- R1: After reset, every status word and every timestamp word of both directions reads zero.
- R2: When a direction is enabled, its valid flag is clear, and its strobe is high with no clear in the same cycle, then after the next clock edge the valid flag (status bit 16) is 1. In the same update, status bits [15:0] hold the strobe's sequence identifier, the low word holds time bits [31:0], and the high word holds time bits [63:32], all sampled in the strobe cycle.
- R3: While the valid flag is set, further strobes leave the status word and both timestamp words unchanged.
- R4: A status write whose data has bit 16 set clears the valid flag after the next edge. The sequence field and the timestamp words keep their values, and the next strobe is captured again. Status bits [31:17] always read zero.
- R5: A status write whose data has bit 16 clear has no effect.
- R6: While the enable input is low, strobes have no effect. A falling enable does not clear a held capture.
- R7: In a cycle where the enable input is high and was low in the previous cycle, the valid flag is cleared, and a strobe in that cycle is dropped.
- R8: A clearing status write in the same cycle as a strobe takes priority: the valid flag ends clear and the held data is unchanged.
- R9: The receive and transmit slots are independent: a strobe, clear or enable change on one direction leaves the other direction's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| now_time | input | 64 | Live time shared by both directions |
| rx_en | input | 1 | Receive timestamping enable; a rising edge clears the slot |
| rx_cap_stb | input | 1 | Receive qualified capture strobe |
| rx_cap_seq | input | 16 | Receive packet sequence identifier |
| rx_sts_we | input | 1 | Receive status write strobe |
| rx_sts_wdata | input | 32 | Receive status write data (bit 16 = clear) |
| rx_status | output | 32 | Receive status: bit 16 valid, bits [15:0] sequence |
| rx_ts_lo | output | 32 | Receive captured time bits [31:0] |
| rx_ts_hi | output | 32 | Receive captured time bits [63:32] |
| tx_en | input | 1 | Transmit timestamping enable; a rising edge clears the slot |
| tx_cap_stb | input | 1 | Transmit qualified capture strobe |
| tx_cap_seq | input | 16 | Transmit packet sequence identifier |
| tx_sts_we | input | 1 | Transmit status write strobe |
| tx_sts_wdata | input | 32 | Transmit status write data (bit 16 = clear) |
| tx_status | output | 32 | Transmit status: bit 16 valid, bits [15:0] sequence |
| tx_ts_lo | output | 32 | Transmit captured time bits [31:0] |
| tx_ts_hi | output | 32 | Transmit captured time bits [63:32] |

## Verification
Two functions can fall in the same cycle: a capture strobe and a clear. The clear comes either from a software write-one to bit 16 or from a rising enable. The bench drives a strobe with a new sequence and a new time in the very cycle of the write, and again in the cycle where the enable returns high. It then judges the result one edge later. The valid flag must read clear, and the sequence and timestamp words must still show the earlier capture rather than the new strobe.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

    // Position of the valid / clear flag in the status word.
    localparam int unsigned STS_VALID_POS = 16;
    localparam int unsigned STS_WORD_W    = 32;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } ts_dir_e;

endpackage

// File: rtl/ts_cap_arm.sv
// Decodes the clear sources (write-one and enable rising edge) and the
// qualified capture request for one direction.
module ts_cap_arm #(
    parameter int unsigned STS_W     = 32,
    parameter int unsigned VALID_POS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             stb,
    input  logic             sts_we,
    input  logic [STS_W-1:0] sts_wdata,
    output logic             clr,
    output logic             cap
);

    typedef struct packed {
        logic en_prev;
    } arm_state_t;

    arm_state_t st_d, st_q;
    logic       en_rise;
    logic       w1c;

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = en;
        en_rise      = en && !st_q.en_prev;
        w1c          = sts_we && sts_wdata[VALID_POS];
        clr          = w1c || en_rise;
        cap          = en && stb && !clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: a write-one clear always blocks the capture request
    a_r8_clear_blocks_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_we && sts_wdata[VALID_POS]) |-> !cap);

endmodule

// File: rtl/ts_cap_slot.sv
// Single-entry capture slot: stores time and sequence, locks until cleared.
module ts_cap_slot #(
    parameter int unsigned TIME_W = 64,
    parameter int unsigned SEQ_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap,
    input  logic [SEQ_W-1:0]  cap_seq,
    input  logic [TIME_W-1:0] now_time,
    output logic              valid,
    output logic [SEQ_W-1:0]  seq,
    output logic [TIME_W-1:0] ts
);

    typedef struct packed {
        logic              valid;
        logic [SEQ_W-1:0]  seq;
        logic [TIME_W-1:0] ts;
    } slot_state_t;

    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.valid = 1'b0;
        end else if (cap && !st_q.valid) begin
            st_d.valid = 1'b1;
            st_d.seq   = cap_seq;
            st_d.ts    = now_time;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.valid;
    assign seq   = st_q.seq;
    assign ts    = st_q.ts;

    // R2: accepted capture sets valid and stores the sampled time and sequence
    a_r2_capture_stores: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !clr && !valid) |=> (valid && ts == $past(now_time) && seq == $past(cap_seq)));

    // R3: a held capture is never overwritten
    a_r3_hold_while_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !clr) |=> (valid && $stable(ts) && $stable(seq)));

    // R4: a clear empties the slot and keeps the data
    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!valid && $stable(ts) && $stable(seq)));

endmodule

// File: rtl/ts_capture_pair.sv
// Receive and transmit timestamp capture slots sharing one live time.
module ts_capture_pair
    import ts_cap_pkg::*;
#(
    parameter int unsigned TIME_W = 64,
    parameter int unsigned SEQ_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now_time,
    input  logic              rx_en,
    input  logic              rx_cap_stb,
    input  logic [SEQ_W-1:0]  rx_cap_seq,
    input  logic              rx_sts_we,
    input  logic [31:0]       rx_sts_wdata,
    output logic [31:0]       rx_status,
    output logic [31:0]       rx_ts_lo,
    output logic [31:0]       rx_ts_hi,
    input  logic              tx_en,
    input  logic              tx_cap_stb,
    input  logic [SEQ_W-1:0]  tx_cap_seq,
    input  logic              tx_sts_we,
    input  logic [31:0]       tx_sts_wdata,
    output logic [31:0]       tx_status,
    output logic [31:0]       tx_ts_lo,
    output logic [31:0]       tx_ts_hi
);

    localparam int unsigned N_DIR  = 2;
    localparam int unsigned WORD_W = TIME_W / 2;
    localparam int unsigned PAD_W  = STS_WORD_W - SEQ_W - 1;

    logic [N_DIR-1:0]             en_a, stb_a, we_a, clr_a, cap_a, valid_a;
    logic [N_DIR-1:0][SEQ_W-1:0]  seq_in_a, seq_a;
    logic [N_DIR-1:0][31:0]       wdata_a, status_a;
    logic [N_DIR-1:0][TIME_W-1:0] ts_a;

    assign en_a[DIR_RX]     = rx_en;
    assign en_a[DIR_TX]     = tx_en;
    assign stb_a[DIR_RX]    = rx_cap_stb;
    assign stb_a[DIR_TX]    = tx_cap_stb;
    assign we_a[DIR_RX]     = rx_sts_we;
    assign we_a[DIR_TX]     = tx_sts_we;
    assign seq_in_a[DIR_RX] = rx_cap_seq;
    assign seq_in_a[DIR_TX] = tx_cap_seq;
    assign wdata_a[DIR_RX]  = rx_sts_wdata;
    assign wdata_a[DIR_TX]  = tx_sts_wdata;

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        ts_cap_arm #(
            .STS_W     (STS_WORD_W),
            .VALID_POS (STS_VALID_POS)
        ) i_arm (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (en_a[d]),
            .stb       (stb_a[d]),
            .sts_we    (we_a[d]),
            .sts_wdata (wdata_a[d]),
            .clr       (clr_a[d]),
            .cap       (cap_a[d])
        );

        ts_cap_slot #(
            .TIME_W (TIME_W),
            .SEQ_W  (SEQ_W)
        ) i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr_a[d]),
            .cap      (cap_a[d]),
            .cap_seq  (seq_in_a[d]),
            .now_time (now_time),
            .valid    (valid_a[d]),
            .seq      (seq_a[d]),
            .ts       (ts_a[d])
        );

        assign status_a[d] = {{PAD_W{1'b0}}, valid_a[d], seq_a[d]};

        // R6: with enable low and slot empty, the slot stays empty
        a_r6_disabled_ignores: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_a[d] && !status_a[d][STS_VALID_POS]) |=> !status_a[d][STS_VALID_POS]);

        // R7: a rising enable leaves the slot empty after the edge
        a_r7_enable_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(en_a[d]) |=> !status_a[d][STS_VALID_POS]);

        // R5: a write with the clear bit low never empties a full slot
        a_r5_write_zero_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (status_a[d][STS_VALID_POS] && we_a[d] && !wdata_a[d][STS_VALID_POS]
             && !$rose(en_a[d])) |=> status_a[d][STS_VALID_POS]);
    end

    assign rx_status = status_a[DIR_RX];
    assign rx_ts_lo  = ts_a[DIR_RX][WORD_W-1:0];
    assign rx_ts_hi  = ts_a[DIR_RX][TIME_W-1:WORD_W];
    assign tx_status = status_a[DIR_TX];
    assign tx_ts_lo  = ts_a[DIR_TX][WORD_W-1:0];
    assign tx_ts_hi  = ts_a[DIR_TX][TIME_W-1:WORD_W];

    // R4: upper status bits read zero
    a_r4_status_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_status[31:17] == '0) && (tx_status[31:17] == '0));

endmodule

// File: tb/test_ts_capture_pair.sv
module test_ts_capture_pair;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 11;

    typedef struct packed {
        logic        en;
        logic        stb;
        logic [15:0] seq;
        logic [63:0] tim;
        logic        we;
        logic        wbit;
        logic        exp_v;
        logic [15:0] exp_seq;
        logic [63:0] exp_ts;
        logic [7:0]  req;
    } vec_t;

    // Receive-direction vectors, applied one per cycle.
    localparam vec_t VECS [N_VEC] = '{
        // R2 capture into empty slot
        '{1'b1, 1'b1, 16'h0011, 64'h0000_0001_0000_0002, 1'b0, 1'b0, 1'b1, 16'h0011, 64'h0000_0001_0000_0002, 8'd2},
        // R3 strobe while full ignored
        '{1'b1, 1'b1, 16'h0022, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, 1'b0, 1'b1, 16'h0011, 64'h0000_0001_0000_0002, 8'd3},
        // R5 write with bit 16 low
        '{1'b1, 1'b0, 16'h0000, 64'h0,                   1'b1, 1'b0, 1'b1, 16'h0011, 64'h0000_0001_0000_0002, 8'd5},
        // R4 write-one clears, data kept
        '{1'b1, 1'b0, 16'h0000, 64'h0,                   1'b1, 1'b1, 1'b0, 16'h0011, 64'h0000_0001_0000_0002, 8'd4},
        // R2 re-armed capture
        '{1'b1, 1'b1, 16'h0033, 64'hDEAD_BEEF_0123_4567, 1'b0, 1'b0, 1'b1, 16'h0033, 64'hDEAD_BEEF_0123_4567, 8'd2},
        // R8 clear and strobe together: clear wins
        '{1'b1, 1'b1, 16'h0044, 64'h5555_5555_5555_5555, 1'b1, 1'b1, 1'b0, 16'h0033, 64'hDEAD_BEEF_0123_4567, 8'd8},
        // R6 disabled strobe ignored
        '{1'b0, 1'b1, 16'h0055, 64'h0000_0000_0000_1234, 1'b0, 1'b0, 1'b0, 16'h0033, 64'hDEAD_BEEF_0123_4567, 8'd6},
        // R7 strobe in enable-rise cycle dropped
        '{1'b1, 1'b1, 16'h0066, 64'h7777_7777_7777_7777, 1'b0, 1'b0, 1'b0, 16'h0033, 64'hDEAD_BEEF_0123_4567, 8'd7},
        // R2 all-ones boundary capture
        '{1'b1, 1'b1, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b1, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'd2},
        // R6 falling enable keeps held capture
        '{1'b0, 1'b0, 16'h0000, 64'h0,                   1'b0, 1'b0, 1'b1, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'd6},
        // R7 rising enable clears stale flag
        '{1'b1, 1'b0, 16'h0000, 64'h0,                   1'b0, 1'b0, 1'b0, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] now_time = '0;
    logic        rx_en = 1'b0, rx_cap_stb = 1'b0, rx_sts_we = 1'b0;
    logic [15:0] rx_cap_seq = '0;
    logic [31:0] rx_sts_wdata = '0;
    logic        tx_en = 1'b0, tx_cap_stb = 1'b0, tx_sts_we = 1'b0;
    logic [15:0] tx_cap_seq = '0;
    logic [31:0] tx_sts_wdata = '0;
    logic [31:0] rx_status, rx_ts_lo, rx_ts_hi, tx_status, tx_ts_lo, tx_ts_hi;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ts_capture_pair i_ts_capture_pair (
        .clk(clk), .rst_n(rst_n), .now_time(now_time),
        .rx_en(rx_en), .rx_cap_stb(rx_cap_stb), .rx_cap_seq(rx_cap_seq),
        .rx_sts_we(rx_sts_we), .rx_sts_wdata(rx_sts_wdata),
        .rx_status(rx_status), .rx_ts_lo(rx_ts_lo), .rx_ts_hi(rx_ts_hi),
        .tx_en(tx_en), .tx_cap_stb(tx_cap_stb), .tx_cap_seq(tx_cap_seq),
        .tx_sts_we(tx_sts_we), .tx_sts_wdata(tx_sts_wdata),
        .tx_status(tx_status), .tx_ts_lo(tx_ts_lo), .tx_ts_hi(tx_ts_hi)
    );

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        rx_cap_stb = 1'b0; rx_sts_we = 1'b0; rx_sts_wdata = '0;
        tx_cap_stb = 1'b0; tx_sts_we = 1'b0; tx_sts_wdata = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // Reset, enables already high
        rx_en = 1'b1; tx_en = 1'b1;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check32("R1 rx_status", rx_status, 32'h0);
        check32("R1 rx_ts_lo", rx_ts_lo, 32'h0);
        check32("R1 rx_ts_hi", rx_ts_hi, 32'h0);
        check32("R1 tx_status", tx_status, 32'h0);
        step(); step();

        // Table walk on the receive direction
        for (int i = 0; i < N_VEC; i++) begin
            rx_en        = VECS[i].en;
            rx_cap_stb   = VECS[i].stb;
            rx_cap_seq   = VECS[i].seq;
            now_time     = VECS[i].tim;
            rx_sts_we    = VECS[i].we;
            rx_sts_wdata = {15'h0, VECS[i].wbit, 16'h0};
            step();
            check32($sformatf("R%0d vec%0d status", VECS[i].req, i), rx_status,
                    {15'h0, VECS[i].exp_v, VECS[i].exp_seq});
            check32($sformatf("R%0d vec%0d ts_lo", VECS[i].req, i), rx_ts_lo, VECS[i].exp_ts[31:0]);
            check32($sformatf("R%0d vec%0d ts_hi", VECS[i].req, i), rx_ts_hi, VECS[i].exp_ts[63:32]);
        end
        idle_inputs();
        // R9 transmit untouched by all receive activity
        check32("R9 tx_status idle", tx_status, 32'h0);
        check32("R9 tx_ts_lo idle", tx_ts_lo, 32'h0);

        // R9 both capture in the same cycle, then clear only receive
        step();
        now_time   = 64'h0102_0304_0506_0708;
        rx_cap_stb = 1'b1; rx_cap_seq = 16'h0DEF;
        tx_cap_stb = 1'b1; tx_cap_seq = 16'h0ABC;
        step();
        idle_inputs();
        check32("R9 tx_status capture", tx_status, 32'h0001_0ABC);
        check32("R9 tx_ts_hi capture", tx_ts_hi, 32'h0102_0304);
        check32("R9 rx_status capture", rx_status, 32'h0001_0DEF);
        rx_sts_we = 1'b1; rx_sts_wdata = 32'hFFFF_FFFF;   // R4 W1C with other bits set
        step();
        idle_inputs();
        check32("R9 rx cleared", rx_status, 32'h0000_0DEF);
        check32("R9 tx still held", tx_status, 32'h0001_0ABC);
        check32("R4 upper status bits", {17'h0, rx_status[31:17]}, 32'h0);

        // R8 on transmit: clear with strobe in same cycle
        now_time   = 64'h9999_9999_9999_9999;
        tx_cap_stb = 1'b1; tx_cap_seq = 16'h1111;
        tx_sts_we  = 1'b1; tx_sts_wdata = 32'h0001_0000;
        step();
        idle_inputs();
        check32("R8 tx clear wins", tx_status, 32'h0000_0ABC);
        check32("R8 tx_ts_lo kept", tx_ts_lo, 32'h0506_0708);

        // R4 re-armed transmit captures again
        tx_cap_stb = 1'b1; tx_cap_seq = 16'h2222;
        step();
        idle_inputs();
        check32("R4 tx rearmed", tx_status, 32'h0001_2222);
        check32("R4 tx_ts_lo new", tx_ts_lo, 32'h9999_9999);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule